// File: doc/BRIEF.md
# Time-Slot Stream Demultiplexer

This block takes a single stream of 32-bit words in which many front-end digitisers share one link by time slots. Each repeating frame opens with a fixed marker word. A fixed number of slots follows the marker, one slot per digitiser, always in the same order. The block finds the marker and counts the slots after it. From that count it knows which digitiser each word belongs to. It passes every nonzero slot word on, tagged with that digitiser's index, so the word sequence of each digitiser can be rebuilt downstream.

Marker words are consumed and never forwarded. An all-zero slot means the digitiser had nothing to send: it is counted and discarded. When the word at the expected marker position is anything other than the marker, the block reports a framing fault, drops lock and hunts for the marker again. Input words carry a valid strobe, and idle cycles may appear anywhere in the stream.

Top module: `slot_demux`

## Requirements
- R1: While reset is high and on the first cycle after it, `locked`, `out_valid` and `align_err` are low, and both counters read zero.
- R2: While unlocked, valid words that differ from the marker `SEP_WORD` produce no output. A valid marker word raises `locked` on the following cycle.
- R3: After a marker, the next `NUM_SLOTS` valid words belong to digitisers 0, 1, … `NUM_SLOTS-1` in that order. The word after them is expected to be a marker.
- R4: A nonzero slot word appears on `out_data` one cycle after it is presented, unchanged, with `out_valid` high for that one cycle and `out_idx` set to its slot index.
- R5: An all-zero slot word produces no output pulse and raises `empty_cnt` by one, in the same cycle that an output would have appeared.
- R6: Marker words at the marker position are never forwarded.
- R7: A valid word at the marker position that is not `SEP_WORD` gives a one-cycle `align_err` pulse on the next cycle. In that same cycle `locked` falls and `err_cnt` rises by one. The block then hunts again and relocks on the next marker.
- R8: A cycle with `in_valid` low changes nothing. The slot position is kept, no output or error appears, and the counters hold.
- R9: With saturation selected (`SATURATE`=1), each counter stops at its all-ones value and stays there.
- R10: A word equal to the marker that arrives in a slot position is treated as ordinary slot data and forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word strobe |
| in_data | input | DATA_W | Input stream word |
| out_valid | output | 1 | One pulse per forwarded slot word |
| out_idx | output | IDX_W | Digitiser index of the forwarded word |
| out_data | output | DATA_W | Forwarded slot word |
| locked | output | 1 | Frame alignment held |
| align_err | output | 1 | One-cycle pulse on a missing marker |
| empty_cnt | output | CNT_W | Count of discarded all-zero slots |
| err_cnt | output | CNT_W | Count of alignment faults |

## Verification
The bench targets the points where slot counting can slip. Idle gaps inside a frame would shift every later index if the position advanced on an invalid cycle. The slot after the last digitiser would be forwarded as data if the wrap were off by one. A marker-valued word in a slot position would cause a false resync if the marker were matched everywhere. After a missed marker, a design that failed to drop lock would keep forwarding misattributed words, and one that forgot to hunt would never relock. Counters run well past their limit to show they hold at all-ones and do not wrap to small values.

// File: rtl/slot_demux_pkg.sv
package slot_demux_pkg;
   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_TRACK = 1'b1
   } sync_state_e;
endpackage

// File: rtl/slot_demux_framer.sv
module slot_demux_framer
   import slot_demux_pkg::*;
#(
   parameter int              DATA_W    = 32,
   parameter int              NUM_SLOTS = 18,
   parameter int              IDX_W     = 5,
   parameter logic [DATA_W-1:0] SEP_WORD = 32'hC3C3_5A5A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              locked,
   output logic              slot_take,
   output logic [IDX_W-1:0]  slot_idx,
   output logic              miss_evt,
   output logic              align_err
);
   localparam int POS_W = $clog2(NUM_SLOTS + 1);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_SLOTS);

   sync_state_e      state_q;
   logic [POS_W-1:0] pos_q;
   logic             is_sep;
   logic             at_marker;

   assign is_sep    = (in_data == SEP_WORD);
   assign at_marker = (pos_q == '0);
   assign locked    = (state_q == ST_TRACK);
   assign slot_take = in_valid && locked && !at_marker;
   assign miss_evt  = in_valid && locked && at_marker && !is_sep;
   assign slot_idx  = IDX_W'(pos_q - POS_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_HUNT;
         pos_q     <= '0;
         align_err <= 1'b0;
      end else begin
         align_err <= miss_evt;
         if (in_valid) begin
            unique case (state_q)
               ST_HUNT: begin
                  if (is_sep) begin
                     state_q <= ST_TRACK;
                     pos_q   <= POS_W'(1);
                  end
               end
               ST_TRACK: begin
                  if (at_marker) begin
                     if (is_sep) begin
                        pos_q <= POS_W'(1);
                     end else begin
                        state_q <= ST_HUNT;
                     end
                  end else if (pos_q == LAST_POS) begin
                     pos_q <= '0;
                  end else begin
                     pos_q <= pos_q + POS_W'(1);
                  end
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/slot_demux_router.sv
module slot_demux_router #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slot_take,
   input  logic [IDX_W-1:0]  slot_idx,
   input  logic [DATA_W-1:0] in_data,
   output logic              empty_evt,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_data
);
   logic is_zero;
   logic fwd;

   assign is_zero   = (in_data == '0);
   assign fwd       = slot_take && !is_zero;
   assign empty_evt = slot_take && is_zero;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= fwd;
         if (fwd) begin
            out_idx  <= slot_idx;
            out_data <= in_data;
         end
      end
   end
endmodule

// File: rtl/slot_demux_counter.sv
module slot_demux_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (count == CNT_MAX) ? count : count + CNT_W'(1);
      end else begin : g_wrap
         assign nxt = count + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (inc) begin
         count <= nxt;
      end
   end
endmodule

// File: rtl/slot_demux.sv
module slot_demux #(
   parameter int                DATA_W    = 32,
   parameter int                NUM_SLOTS = 18,
   parameter int                IDX_W     = $clog2(NUM_SLOTS),
   parameter int                CNT_W     = 16,
   parameter bit                SATURATE  = 1'b1,
   parameter logic [DATA_W-1:0] SEP_WORD  = 32'hC3C3_5A5A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_data,
   output logic              locked,
   output logic              align_err,
   output logic [CNT_W-1:0]  empty_cnt,
   output logic [CNT_W-1:0]  err_cnt
);
   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("slot_demux: NUM_SLOTS must be at least 2");
      end
      if ((2 ** IDX_W) < NUM_SLOTS) begin : g_bad_idx
         $error("slot_demux: IDX_W too narrow for NUM_SLOTS");
      end
      if (SEP_WORD == '0) begin : g_bad_sep
         $error("slot_demux: SEP_WORD must differ from the empty-slot value");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("slot_demux: CNT_W must be positive");
      end
   endgenerate

   logic             slot_take;
   logic [IDX_W-1:0] slot_idx;
   logic             miss_evt;
   logic             empty_evt;

   slot_demux_framer #(
      .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .SEP_WORD(SEP_WORD)
   ) framer_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .locked(locked), .slot_take(slot_take), .slot_idx(slot_idx),
      .miss_evt(miss_evt), .align_err(align_err)
   );

   slot_demux_router #(
      .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) router_i (
      .clk(clk), .rst(rst), .slot_take(slot_take), .slot_idx(slot_idx),
      .in_data(in_data), .empty_evt(empty_evt), .out_valid(out_valid),
      .out_idx(out_idx), .out_data(out_data)
   );

   slot_demux_counter #(
      .CNT_W(CNT_W), .SATURATE(SATURATE)
   ) empty_ctr_i (
      .clk(clk), .rst(rst), .inc(empty_evt), .count(empty_cnt)
   );

   slot_demux_counter #(
      .CNT_W(CNT_W), .SATURATE(SATURATE)
   ) err_ctr_i (
      .clk(clk), .rst(rst), .inc(miss_evt), .count(err_cnt)
   );
endmodule

// File: rtl/slot_demux_chk.sv
module slot_demux_chk #(
   parameter int                DATA_W    = 32,
   parameter int                NUM_SLOTS = 18,
   parameter int                IDX_W     = 5,
   parameter int                CNT_W     = 16,
   parameter bit                SATURATE  = 1'b1,
   parameter logic [DATA_W-1:0] SEP_WORD  = 32'hC3C3_5A5A
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic [IDX_W-1:0]  out_idx,
   input logic [DATA_W-1:0] out_data,
   input logic              locked,
   input logic              align_err,
   input logic [CNT_W-1:0]  empty_cnt,
   input logic [CNT_W-1:0]  err_cnt
);
   p_out_needs_lock_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(locked));

   p_idx_in_range_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_idx) < NUM_SLOTS));

   p_data_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($past(in_valid) && out_data == $past(in_data)));

   p_no_zero_out_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data != '0));

   p_err_drops_lock_r7: assert property (@(posedge clk) disable iff (rst)
      align_err |-> (!locked && $past(locked) && err_cnt != $past(err_cnt) || &err_cnt));

   p_err_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      align_err |=> !align_err);

   p_gap_holds_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !align_err && $stable(locked)
                     && $stable(empty_cnt) && $stable(err_cnt)));

   generate
      if (SATURATE) begin : g_sat_chk
         p_cnt_hold_max_r9: assert property (@(posedge clk) disable iff (rst)
            (&$past(empty_cnt)) |-> (&empty_cnt));
         p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
            (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + CNT_W'(1)));
      end
   endgenerate
endmodule

bind slot_demux slot_demux_chk #(
   .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W),
   .CNT_W(CNT_W), .SATURATE(SATURATE), .SEP_WORD(SEP_WORD)
) chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
   .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
   .locked(locked), .align_err(align_err),
   .empty_cnt(empty_cnt), .err_cnt(err_cnt)
);

// File: tb/slot_demux_tb_top.sv
module slot_demux_tb_top;
   localparam int          NS  = 18;
   localparam int          IW  = 5;
   localparam int          CW  = 4;
   localparam logic [31:0] SEP = 32'hC3C3_5A5A;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic [IW-1:0] out_idx;
   logic [31:0] out_data;
   logic        locked;
   logic        align_err;
   logic [CW-1:0] empty_cnt;
   logic [CW-1:0] err_cnt;

   always #5 clk = ~clk;

   slot_demux #(
      .DATA_W(32), .NUM_SLOTS(NS), .IDX_W(IW), .CNT_W(CW),
      .SATURATE(1'b1), .SEP_WORD(SEP)
   ) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
      .locked(locked), .align_err(align_err),
      .empty_cnt(empty_cnt), .err_cnt(err_cnt)
   );

   int    total = 0;
   int    bad   = 0;
   string cur_req = "R1";

   // reference model state
   bit          m_locked;
   int          m_pos;
   bit          m_ov;
   int          m_idx;
   logic [31:0] m_data;
   bit          m_ae;
   int          m_empty;
   int          m_errc;
   int          cmax;

   initial cmax = (1 << CW) - 1;

   always @(posedge clk) begin
      m_ov = 0;
      m_ae = 0;
      if (rst) begin
         m_locked = 0; m_pos = 0; m_empty = 0; m_errc = 0;
      end else if (in_valid) begin
         if (!m_locked) begin
            if (in_data == SEP) begin
               m_locked = 1; m_pos = 1;
            end
         end else if (m_pos == 0) begin
            if (in_data == SEP) m_pos = 1;
            else begin
               m_ae = 1; m_locked = 0;
               if (m_errc < cmax) m_errc++;
            end
         end else begin
            if (in_data == 0) begin
               if (m_empty < cmax) m_empty++;
            end else begin
               m_ov = 1; m_idx = m_pos - 1; m_data = in_data;
            end
            m_pos = (m_pos == NS) ? 0 : m_pos + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(out_valid == m_ov, "out_valid", longint'(out_valid), longint'(m_ov));
      if (m_ov && out_valid) begin
         chk(int'(out_idx) == m_idx, "out_idx", longint'(out_idx), longint'(m_idx));
         chk(out_data == m_data, "out_data", longint'(out_data), longint'(m_data));
      end
      chk(locked == m_locked, "locked", longint'(locked), longint'(m_locked));
      chk(align_err == m_ae, "align_err", longint'(align_err), longint'(m_ae));
      chk(int'(empty_cnt) == m_empty, "empty_cnt", longint'(empty_cnt), longint'(m_empty));
      chk(int'(err_cnt) == m_errc, "err_cnt", longint'(err_cnt), longint'(m_errc));
   endtask

   task automatic step(input bit v, input logic [31:0] d);
      @(negedge clk);
      compare();
      in_valid = v;
      in_data  = d;
   endtask

   function automatic logic [31:0] slot_word(input int f, input int i);
      return {8'(f), 8'(i), 16'hBE01};
   endfunction

   // one frame; slots where (i % zmod) == zsel carry zero, zmod 0 means none
   task automatic send_frame(input int f, input int zmod, input int zsel);
      step(1, SEP);
      for (int i = 0; i < NS; i++) begin
         if (zmod != 0 && (i % zmod) == zsel) step(1, 32'h0);
         else step(1, slot_word(f, i));
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      compare();
      rst = 1'b0;
      @(negedge clk);
      // R1: state right after reset
      cur_req = "R1";
      chk(!locked && !out_valid && !align_err, "reset outputs", longint'({locked, out_valid, align_err}), 0);
      chk(empty_cnt == 0 && err_cnt == 0, "reset counters", longint'({empty_cnt, err_cnt}), 0);

      // R2: junk while unlocked, then lock on marker
      cur_req = "R2";
      step(1, 32'h0000_0005); step(1, 32'h0); step(1, 32'h1234_5678);
      step(1, SEP);
      step(0, 32'h0);
      chk(locked == 1'b1, "lock after marker", longint'(locked), 1);

      // R3/R4/R6: full frames, all nonzero, per-slot order
      cur_req = "R3";
      for (int i = 0; i < NS; i++) step(1, slot_word(0, i));
      cur_req = "R4";
      send_frame(1, 0, 0);
      cur_req = "R6";
      send_frame(2, 0, 0);

      // R5: empty slots mixed in
      cur_req = "R5";
      send_frame(3, 3, 1);
      send_frame(4, 5, 0);

      // R8: gaps inside a frame and at the marker position
      cur_req = "R8";
      step(0, SEP);
      step(1, SEP);
      for (int i = 0; i < NS; i++) begin
         step(1, slot_word(5, i));
         if (i % 4 == 2) begin step(0, 32'h0); step(0, SEP); end
      end
      step(0, 32'hDEAD_0000);

      // R10: marker value in a slot position
      cur_req = "R10";
      step(1, SEP);
      for (int i = 0; i < NS; i++) step(1, (i == 3 || i == NS - 1) ? SEP : slot_word(6, i));
      send_frame(7, 0, 0);

      // R7: missing marker, hunt, relock
      cur_req = "R7";
      step(1, 32'h0BAD_0001);
      step(0, 32'h0);
      chk(locked == 1'b0, "lock dropped", longint'(locked), 0);
      step(1, slot_word(8, 1)); step(1, 32'h0);
      send_frame(8, 4, 2);
      step(1, 32'h0);   // zero at marker position is also a fault
      step(1, SEP);
      for (int i = 0; i < NS; i++) step(1, slot_word(9, i));

      // R9: drive both counters past their limit
      cur_req = "R9";
      send_frame(10, 1, 0);
      send_frame(11, 1, 0);
      for (int k = 0; k < cmax + 2; k++) begin
         step(1, 32'h7777_0000 + 32'(k));
         step(1, SEP);
         for (int i = 0; i < NS; i++) step(1, 32'h0);
      end
      step(1, 32'h0BAD_0002);
      step(0, 32'h0);
      step(0, 32'h0);
      chk(int'(empty_cnt) == cmax, "empty_cnt saturated", longint'(empty_cnt), longint'(cmax));
      chk(int'(err_cnt) == cmax, "err_cnt saturated", longint'(err_cnt), longint'(cmax));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule